// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It walks a radix page table with four levels that lives in memory. A requester hands over the virtual address together with the physical base of the top-level table. The walker then reads one 64-bit entry per level through a simple read port. Each entry it reads either points to the next table or, at the last level, to the 4 KB frame. The answer is either the physical address or a fault flag. A fault means an entry along the way had its present bit clear.

Upper-level entries that were found present are kept in a small fully associative walk cache. Each cached entry is tagged by its level and by the virtual-address prefix that selected it. When a new walk starts, the deepest matching cached entry supplies the table base for the level below it, so the reads for the skipped levels never happen. A flush input clears the cache. It must be pulsed whenever the root table changes or an upper-level entry is rewritten in memory.

The controller is a four-state machine:
- **IDLE**: ready for a request. An accepted request (transition *accept*) moves to ISSUE, starting at level 0 from the root or deeper on a cache hit.
- **ISSUE**: presents the entry read. The *granted* transition moves to WAIT.
- **WAIT**: holds until the read data returns. The *descend* transition goes back to ISSUE for the next level. The *leaf* and *fault* transitions go to DONE.
- **DONE**: shows the response for one cycle. The *retire* transition returns to IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and mem_req_valid are 0.
- R2: A walk visits table levels 0, 1, 2 and 3 in that order, using VA bits [47:39], [38:30], [29:21] and [20:12] as the index at each level. The entry address is table base × 4096 + index × 8. The level-0 base is req_root[51:12], and each later base is bits [51:12] of the entry read before it.
- R3: A walk with no cache hit issues exactly four reads. When all entries are present, rsp_pa is {leaf entry bits [51:12], VA bits [11:0]} and rsp_fault is 0.
- R4: An entry whose bit 0 (present) is 0 ends the walk at once. The response has rsp_fault = 1, and no further read is issued for that request.
- R5: When the level-2 entry for the same VA bits [47:21] is cached, a walk issues only the level-3 read.
- R6: When several cached levels match, the deepest one is used, so the walk issues 4 − (cached level + 1) reads.
- R7: A non-present entry is never cached. Present entries read above it in a faulting walk are cached.
- R8: A flush pulse invalidates every cache entry, so the next walk issues four reads. A request accepted in the same cycle as a flush sees no hit.
- R9: mem_req_valid stays high with a stable mem_req_addr until mem_req_ready is seen. At most one read is outstanding, and response latency may be any number of cycles.
- R10: req_ready is 0 from acceptance until the response has been given.
- R11: rsp_valid is a single-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all walk-cache entries |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 48 | Virtual address to translate |
| req_root | input | 52 | Physical base of the level-0 table (bits 11:0 ignored) |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Walk hit a non-present entry |
| rsp_pa | output | 52 | Physical address (valid when rsp_fault is 0) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 52 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |

## Verification
A wrong tag, level or valid bit in the walk cache does not corrupt the answer itself. It shows up at the memory port on the very next walk that shares a prefix: the first read goes to the wrong level's table, and the walk issues a different number of reads. A wrong level counter or table base sends mem_req_addr to the wrong entry on the first read after the bad state, in the same cycle that read is issued. A mis-sequenced controller shows up within one cycle as req_ready rising mid-walk, rsp_valid lasting more than one cycle, or a read address changing while stalled.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W    = 48;
    localparam int PA_W    = 52;
    localparam int IDX_W   = 9;
    localparam int OFS_W   = 12;
    localparam int N_LVL   = 4;
    localparam int ENT_W   = 64;
    localparam int BASE_W  = PA_W - OFS_W;
    localparam int UP_LVLS = N_LVL - 1;
    localparam int TAG_W   = IDX_W * UP_LVLS;
    localparam int ENT_SH  = $clog2(ENT_W / 8);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_st_t;

    // keeps the top IDX_W*(lvl+1) bits of a prefix
    function automatic logic [TAG_W-1:0] pfx_mask(input int lvl);
        return ~({TAG_W{1'b1}} >> (IDX_W * (lvl + 1)));
    endfunction
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr
    import ptw_pkg::*;
(
    input  logic [BASE_W-1:0] base,
    input  logic [VA_W-1:0]   va,
    input  logic [1:0]        lvl,
    output logic [PA_W-1:0]   addr
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx  = va[VA_W-1 - IDX_W*int'(lvl) -: IDX_W];
        addr = {base, idx, {ENT_SH{1'b0}}};
    end
endmodule

// File: rtl/ptw_wcache.sv
module ptw_wcache
    import ptw_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [TAG_W-1:0]  lk_pfx,
    output logic              lk_hit,
    output logic [1:0]        lk_start,
    output logic [BASE_W-1:0] lk_base,
    input  logic              fill_en,
    input  logic [1:0]        fill_lvl,
    input  logic [TAG_W-1:0]  fill_pfx,
    input  logic [BASE_W-1:0] fill_base
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0]  vld_q;
    logic [1:0]        lvl_q  [DEPTH];
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [BASE_W-1:0] base_q [DEPTH];
    logic [PTR_W-1:0]  ptr_q;
    logic [DEPTH-1:0]  hv     [UP_LVLS];

    for (genvar l = 0; l < UP_LVLS; l++) begin : g_lvl
        for (genvar i = 0; i < DEPTH; i++) begin : g_ent
            assign hv[l][i] = vld_q[i] && (lvl_q[i] == 2'(l))
                              && (tag_q[i] == (lk_pfx & pfx_mask(l)));
        end
        AST_UNIQUE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hv[l])) else $error("duplicate cache entry"); // R6
    end

    // later (deeper) levels overwrite earlier matches
    always_comb begin
        lk_hit   = 1'b0;
        lk_start = '0;
        lk_base  = '0;
        for (int l = 0; l < UP_LVLS; l++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hv[l][i]) begin
                    lk_hit   = 1'b1;
                    lk_start = 2'(l + 1);
                    lk_base  = base_q[i];
                end
            end
        end
        if (flush) lk_hit = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (flush) begin
            vld_q <= '0;
        end else if (fill_en) begin
            vld_q[ptr_q]  <= 1'b1;
            lvl_q[ptr_q]  <= fill_lvl;
            tag_q[ptr_q]  <= fill_pfx & pfx_mask(int'(fill_lvl));
            base_q[ptr_q] <= fill_base;
            ptr_q <= (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int WC_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    input  logic [PA_W-1:0]  req_root,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data
);
    localparam logic [1:0] LEAF_LVL = 2'(N_LVL - 1);

    walk_st_t          state_q, state_d;
    logic [1:0]        lvl_q;
    logic [BASE_W-1:0] base_q;
    logic [VA_W-1:0]   va_q;
    logic [PA_W-1:0]   pa_q;
    logic              fault_q;
    logic [2:0]        rd_cnt_q;

    logic              lk_hit;
    logic [1:0]        lk_start;
    logic [BASE_W-1:0] lk_base;
    logic              ent_present;
    logic              fill_en;
    logic [BASE_W-1:0] ent_base;

    assign ent_present = mem_rsp_data[0];
    assign ent_base    = mem_rsp_data[PA_W-1:OFS_W];
    assign fill_en     = (state_q == ST_WAIT) && mem_rsp_valid
                         && ent_present && (lvl_q != LEAF_LVL);

    ptw_wcache #(.DEPTH(WC_DEPTH)) u_wcache (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_pfx    (req_va[VA_W-1 -: TAG_W]),
        .lk_hit    (lk_hit),
        .lk_start  (lk_start),
        .lk_base   (lk_base),
        .fill_en   (fill_en),
        .fill_lvl  (lvl_q),
        .fill_pfx  (va_q[VA_W-1 -: TAG_W]),
        .fill_base (ent_base)
    );

    ptw_addr u_addr (
        .base (base_q),
        .va   (va_q),
        .lvl  (lvl_q),
        .addr (mem_req_addr)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid)     state_d = ST_ISSUE;
            ST_ISSUE: if (mem_req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid)
                          state_d = (!ent_present || lvl_q == LEAF_LVL) ? ST_DONE : ST_ISSUE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            lvl_q    <= '0;
            base_q   <= '0;
            va_q     <= '0;
            pa_q     <= '0;
            fault_q  <= 1'b0;
            rd_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    va_q     <= req_va;
                    rd_cnt_q <= '0;
                    lvl_q    <= lk_hit ? lk_start : 2'd0;
                    base_q   <= lk_hit ? lk_base  : req_root[PA_W-1:OFS_W];
                end
                ST_ISSUE: if (mem_req_ready) rd_cnt_q <= rd_cnt_q + 3'd1;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        fault_q <= 1'b1;
                        pa_q    <= '0;
                    end else if (lvl_q == LEAF_LVL) begin
                        fault_q <= 1'b0;
                        pa_q    <= {ent_base, va_q[OFS_W-1:0]};
                    end else begin
                        base_q <= ent_base;
                        lvl_q  <= lvl_q + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        rsp_valid     = (state_q == ST_DONE);
        rsp_fault     = fault_q;
        rsp_pa        = pa_q;
    end

    AST_HOLD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr))
        else $error("read dropped or changed while stalled"); // R9
    AST_RSP_ONLY_WAITING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> state_q == ST_WAIT)
        else $error("read data with no read outstanding"); // R9
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid)
        else $error("response longer than one cycle"); // R11
    AST_READ_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rd_cnt_q >= 3'd1) && (rd_cnt_q <= 3'(N_LVL)))
        else $error("walk read count out of range"); // R3
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_pa[OFS_W-1:0] == va_q[OFS_W-1:0])
        else $error("page offset altered"); // R3
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_va = '0;
    logic [51:0] req_root = '0;
    logic        rsp_valid, rsp_fault;
    logic [51:0] rsp_pa;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;

    always #10 clk = ~clk;

    pt_walker u_dut (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [63:0] pmem [logic [51:0]];
    logic [39:0] mc   [logic [28:0]];
    int          installs = 0;
    logic [39:0] next_tbl = 40'h100;

    logic [51:0] seen [8];
    int          n_seen = 0;
    bit          hold_bad = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [51:0] a);
        return pmem.exists(a) ? pmem[a] : 64'h0;
    endfunction

    function automatic logic [8:0] vidx(input logic [47:0] va, input int l);
        return va[47 - 9*l -: 9];
    endfunction

    function automatic logic [28:0] mkey(input logic [47:0] va, input int l);
        logic [26:0] p;
        p = va[47:21] & ~(27'h7FF_FFFF >> (9*(l+1)));
        return {2'(l), p};
    endfunction

    // write present entries for levels below 'upto'; upto==4 maps the leaf too
    task automatic map_page(input logic [47:0] va, input logic [51:0] root,
                            input logic [39:0] frame, input int upto);
        logic [39:0] b = root[51:12];
        for (int l = 0; l < 4 && l < upto; l++) begin
            logic [51:0] a = {b, vidx(va, l), 3'b000};
            if (l == 3) pmem[a] = {12'h0, frame, 12'h001};
            else begin
                if (!rd(a)[0]) begin
                    pmem[a] = {12'h0, next_tbl, 12'h001};
                    next_tbl++;
                end
                b = rd(a)[51:12];
            end
        end
    endtask

    task automatic ref_walk(input logic [47:0] va, input logic [51:0] root,
                            output logic [51:0] pa, output bit flt, output int n,
                            output logic [51:0] ea [4]);
        int start = 0;
        logic [39:0] b = root[51:12];
        pa = '0; flt = 0; n = 0;
        for (int k = 0; k < 4; k++) ea[k] = '0;
        for (int l = 2; l >= 0; l--) begin
            if (mc.exists(mkey(va, l))) begin
                start = l + 1; b = mc[mkey(va, l)];
                break;
            end
        end
        for (int l = start; l < 4; l++) begin
            logic [51:0] a = {b, vidx(va, l), 3'b000};
            logic [63:0] e = rd(a);
            ea[n] = a; n++;
            if (!e[0]) begin flt = 1; break; end
            if (l == 3) pa = {e[51:12], va[11:0]};
            else begin
                mc[mkey(va, l)] = e[51:12];
                installs++;
                b = e[51:12];
            end
        end
    endtask

    task automatic do_flush();
        @(negedge clk) flush = 1'b1;
        @(negedge clk) flush = 1'b0;
        mc.delete();
        installs = 0;
    endtask

    task automatic walk(input logic [47:0] va, input logic [51:0] root, input string tag);
        logic [51:0] epa;
        logic [51:0] ea [4];
        bit eflt;
        int en;
        int t = 0;
        bit busy_bad = 0;
        ref_walk(va, root, epa, eflt, en, ea);
        @(negedge clk);
        n_seen = 0;
        req_va = va; req_root = root; req_valid = 1'b1;
        @(negedge clk) req_valid = 1'b0;
        while (!rsp_valid && t < 200) begin
            if (req_ready) busy_bad = 1;
            @(negedge clk); t++;
        end
        check(t < 200, {tag, " timeout"}, 64'(t), 64'd200);
        check(!busy_bad, "R10 req_ready during walk", 64'(busy_bad), 64'd0);
        check(rsp_fault == eflt, {tag, " fault"}, 64'(rsp_fault), 64'(eflt));
        if (!eflt) check(rsp_pa == epa, {tag, " pa"}, 64'(rsp_pa), 64'(epa));
        check(n_seen == en, {tag, " read count"}, 64'(n_seen), 64'(en));
        for (int k = 0; k < en && k < n_seen && k < 4; k++)
            check(seen[k] == ea[k], "R2 entry address", 64'(seen[k]), 64'(ea[k]));
        @(negedge clk);
        check(!rsp_valid, "R11 pulse width", 64'(rsp_valid), 64'd0);
    endtask

    // memory model: random grant and latency
    initial begin
        logic [51:0] pend_addr = '0;
        logic [51:0] stall_addr = '0;
        bit pend = 0, stall_prev = 0;
        int lat = 0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            if (stall_prev && (!mem_req_valid || mem_req_addr != stall_addr)) hold_bad = 1;
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1; mem_rsp_data = rd(pend_addr); pend = 0;
                end else lat--;
            end
            mem_req_ready = ($urandom_range(3) != 0);
            if (mem_req_valid && mem_req_ready) begin
                pend = 1; pend_addr = mem_req_addr; lat = $urandom_range(3);
                if (n_seen < 8) seen[n_seen] = mem_req_addr;
                n_seen++;
            end
            stall_prev = mem_req_valid && !mem_req_ready;
            stall_addr = mem_req_addr;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [51:0] root = 52'h10_000;
        logic [47:0] va1 = {9'h001, 9'h002, 9'h003, 9'h004, 12'hABC};
        logic [47:0] va2 = {9'h001, 9'h002, 9'h005, 9'h006, 12'h010};
        logic [47:0] va3 = {9'h007, 9'h008, 9'h009, 9'h00A, 12'h555};
        logic [47:0] va4 = {9'h1FF, 9'h000, 9'h000, 9'h000, 12'h000};
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 req_ready", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);

        map_page(va1, root, 40'hA_BCDE, 4);
        walk(va1, root, "R3 cold walk");
        walk({va1[47:12], 12'h123}, root, "R5 same page");
        map_page(va2, root, 40'h1_2345, 4);
        walk(va2, root, "R6 deepest match");
        map_page(va3, root, 40'h0, 2);
        walk(va3, root, "R4 fault at level 2");
        map_page(va3, root, 40'h7_7777, 4);
        walk(va3, root, "R7 no fill on fault");
        do_flush();
        walk(va1, root, "R8 after flush");
        walk(va4, root, "R4 fault at level 0");

        for (int n = 0; n < 300; n++) begin
            logic [47:0] va;
            va = {9'(9'h020 + $urandom_range(1)), 9'(9'h030 + $urandom_range(2)),
                  9'(9'h040 + $urandom_range(2)), 9'(9'h050 + $urandom_range(3)),
                  12'($urandom)};
            if (installs > 5 || $urandom_range(15) == 0) do_flush();
            if ($urandom_range(3) != 0) map_page(va, root, 40'($urandom), 4);
            else map_page(va, root, 40'($urandom), $urandom_range(3));
            walk(va, root, "R3 random walk");
        end

        check(!hold_bad, "R9 stalled read held", 64'(hold_bad), 64'd0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule